// File: doc/BRIEF.md
# Trap Entry Control Unit

This unit performs the architectural state change that happens when a hart with a machine level and a supervisor level takes a trap. A trap request arrives with a flag that tells interrupts from exceptions, a cause number, the faulting address and the PC of the trapping instruction. In the same cycle the unit decides whether the trap is handled at supervisor or machine level. The decision uses the current privilege and one of two delegation vectors, which are supplied from outside. On the rising edge where the request is present, the unit commits the result: the cause register, the exception PC, the trap value, the stacked enable and privilege fields, the new PC and the new privilege.

The privilege level and the global interrupt enables live inside the unit. A simple write port lets the surrounding core set them, for example when it returns from a handler. The delegation vectors and the two vector-base values are plain inputs.

Top module: `trap_entry_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, privilege reads 3 (machine). Every cause, exception-PC and trap-value register reads 0, all status bits read 0, and the new-PC output reads 0.
- R2: An interrupt (trap_is_irq=1) takes its delegation bit from ideleg. An exception takes its delegation bit from edeleg.
- R3: A trap is handled at supervisor level (privilege 1) only if the current privilege is 0 or 1 and the selected delegation vector has bit [cause] set. Otherwise it is handled at machine level, including every trap taken while the privilege is 3.
- R4: An exception with cause 8 (environment call) is recorded as cause 8 from privilege 0, 9 from privilege 1 and 11 from privilege 3. The rewritten cause is also the index used for delegation.
- R5: The trap value written is trap_addr for the exception causes 0, 1, 4, 5, 6, 7, 12, 13 and 15. For every other exception cause, and for every interrupt, it is 0.
- R6: On supervisor entry, SPIE takes the old SIE, SPP takes 1 if the old privilege was 1 and 0 otherwise, and SIE clears. The machine fields MIE, MPIE and MPP are unchanged.
- R7: On machine entry, MPIE takes the old MIE, MPP takes the old 2-bit privilege, and MIE clears. The supervisor fields SIE, SPIE and SPP are unchanged.
- R8: The target level's cause register gets {trap_is_irq, zeros, cause}, with bit 31 marking an interrupt. Its exception PC gets cur_pc and its trap value is written as in R5. The other level's cause, exception PC and trap value keep their values.
- R9: The new PC is the target level's vector base with bits [1:0] cleared. When the trap is an interrupt and base bits [1:0] equal 1, 4*cause is added to it.
- R10: After a trap the privilege equals the target level: 1 for supervisor, 3 for machine.
- R11: When st_wr_en is high and no trap is requested, privilege, SIE and MIE load from the write port, and a privilege value of 2 is stored as 0. A trap in the same cycle takes precedence and the write is dropped.
- R12: In a cycle with neither a trap nor a write, all state and outputs hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trap_valid | input | 1 | Trap taken this cycle |
| trap_is_irq | input | 1 | 1 = interrupt, 0 = exception |
| trap_cause | input | CAUSE_W | Cause number (8 = environment call for exceptions) |
| trap_addr | input | XLEN | Faulting address |
| cur_pc | input | XLEN | PC of the trapping instruction |
| edeleg | input | 2**CAUSE_W | Exception delegation vector |
| ideleg | input | 2**CAUSE_W | Interrupt delegation vector |
| stvec | input | XLEN | Supervisor vector base, bits [1:0] = mode |
| mtvec | input | XLEN | Machine vector base, bits [1:0] = mode |
| st_wr_en | input | 1 | Load privilege and enables |
| st_wr_priv | input | 2 | Privilege to load |
| st_wr_sie | input | 1 | SIE value to load |
| st_wr_mie | input | 1 | MIE value to load |
| priv_o | output | 2 | Current privilege (0 U, 1 S, 3 M) |
| sie_o | output | 1 | Supervisor interrupt enable |
| spie_o | output | 1 | Supervisor previous enable |
| spp_o | output | 1 | Supervisor previous privilege |
| mie_o | output | 1 | Machine interrupt enable |
| mpie_o | output | 1 | Machine previous enable |
| mpp_o | output | 2 | Machine previous privilege |
| scause_o | output | XLEN | Supervisor cause |
| sepc_o | output | XLEN | Supervisor exception PC |
| stval_o | output | XLEN | Supervisor trap value |
| mcause_o | output | XLEN | Machine cause |
| mepc_o | output | XLEN | Machine exception PC |
| mtval_o | output | XLEN | Machine trap value |
| pc_o | output | XLEN | New PC after the last trap |

## Verification
The hardest case to reach is a trap delegated from supervisor privilege. The unit leaves reset in machine mode, and from there nothing is ever delegated. The only ways into privilege 1 are the write port or an earlier delegated trap. The stimulus therefore writes random privileges through the port, including the reserved value 2, and sets delegation vectors densely, so that chains of supervisor traps occur. Directed cases add environment calls from each privilege, with delegation bits 8, 9 and 11 set separately, and vectored interrupts with mode bits 1 and 2.

// File: rtl/trap_pkg.sv
package trap_pkg;
  typedef enum logic [1:0] {
    PRIV_U   = 2'd0,
    PRIV_S   = 2'd1,
    PRIV_RSV = 2'd2,
    PRIV_M   = 2'd3
  } priv_e;

  localparam int unsigned ENV_CALL_U = 8;
  localparam int unsigned ENV_CALL_S = 9;
  localparam int unsigned ENV_CALL_M = 11;
  localparam int unsigned NUM_LEVELS = 2;  // index 0 = supervisor, 1 = machine
endpackage

// File: rtl/trap_cause_sel.sv
module trap_cause_sel #(
  parameter int XLEN    = 32,
  parameter int CAUSE_W = 5,
  parameter logic [(1<<CAUSE_W)-1:0] ADDR_CAUSE_MASK = 'hB0F3
) (
  input  logic               is_irq,
  input  logic [CAUSE_W-1:0] cause_in,
  input  logic [1:0]         priv,
  input  logic [XLEN-1:0]    fault_addr,
  output logic [CAUSE_W-1:0] cause_out,
  output logic [XLEN-1:0]    tval
);
  import trap_pkg::*;

  always_comb begin
    cause_out = cause_in;
    if (!is_irq && (cause_in == CAUSE_W'(ENV_CALL_U))) begin
      case (priv)
        PRIV_S:  cause_out = CAUSE_W'(ENV_CALL_S);
        PRIV_M:  cause_out = CAUSE_W'(ENV_CALL_M);
        default: cause_out = CAUSE_W'(ENV_CALL_U);
      endcase
    end
  end

  always_comb begin
    if (!is_irq && ADDR_CAUSE_MASK[cause_out]) tval = fault_addr;
    else                                       tval = '0;
  end
endmodule

// File: rtl/trap_router.sv
module trap_router #(
  parameter int CAUSE_W = 5
) (
  input  logic                    is_irq,
  input  logic [CAUSE_W-1:0]      cause,
  input  logic [1:0]              priv,
  input  logic [(1<<CAUSE_W)-1:0] edeleg,
  input  logic [(1<<CAUSE_W)-1:0] ideleg,
  output logic                    to_s
);
  import trap_pkg::*;

  logic [(1<<CAUSE_W)-1:0] deleg_vec;

  always_comb begin
    deleg_vec = is_irq ? ideleg : edeleg;
    to_s      = (priv != PRIV_M) && deleg_vec[cause];
  end
endmodule

// File: rtl/trap_vec_calc.sv
module trap_vec_calc #(
  parameter int XLEN    = 32,
  parameter int CAUSE_W = 5
) (
  input  logic [XLEN-1:0]    tvec,
  input  logic               is_irq,
  input  logic [CAUSE_W-1:0] cause,
  output logic [XLEN-1:0]    vec_pc
);
  logic [XLEN-1:0] base;
  logic [XLEN-1:0] offset;

  always_comb begin
    base   = {tvec[XLEN-1:2], 2'b00};
    offset = (is_irq && (tvec[1:0] == 2'b01)) ? (XLEN'(cause) << 2) : '0;
    vec_pc = base + offset;
  end
endmodule

// File: rtl/trap_entry_ctrl.sv
module trap_entry_ctrl #(
  parameter int XLEN    = 32,
  parameter int CAUSE_W = 5
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    trap_valid,
  input  logic                    trap_is_irq,
  input  logic [CAUSE_W-1:0]      trap_cause,
  input  logic [XLEN-1:0]         trap_addr,
  input  logic [XLEN-1:0]         cur_pc,
  input  logic [(1<<CAUSE_W)-1:0] edeleg,
  input  logic [(1<<CAUSE_W)-1:0] ideleg,
  input  logic [XLEN-1:0]         stvec,
  input  logic [XLEN-1:0]         mtvec,
  input  logic                    st_wr_en,
  input  logic [1:0]              st_wr_priv,
  input  logic                    st_wr_sie,
  input  logic                    st_wr_mie,
  output logic [1:0]              priv_o,
  output logic                    sie_o,
  output logic                    spie_o,
  output logic                    spp_o,
  output logic                    mie_o,
  output logic                    mpie_o,
  output logic [1:0]              mpp_o,
  output logic [XLEN-1:0]         scause_o,
  output logic [XLEN-1:0]         sepc_o,
  output logic [XLEN-1:0]         stval_o,
  output logic [XLEN-1:0]         mcause_o,
  output logic [XLEN-1:0]         mepc_o,
  output logic [XLEN-1:0]         mtval_o,
  output logic [XLEN-1:0]         pc_o
);
  import trap_pkg::*;

  localparam int PAD_W = XLEN - 1 - CAUSE_W;

  // state registers
  logic [1:0]      priv_q, priv_n;
  logic            sie_q, sie_n, spie_q, spie_n, spp_q, spp_n;
  logic            mie_q, mie_n, mpie_q, mpie_n;
  logic [1:0]      mpp_q, mpp_n;
  logic [XLEN-1:0] scause_q, scause_n, sepc_q, sepc_n, stval_q, stval_n;
  logic [XLEN-1:0] mcause_q, mcause_n, mepc_q, mepc_n, mtval_q, mtval_n;
  logic [XLEN-1:0] pc_q, pc_n;

  // datapath
  logic [CAUSE_W-1:0] eff_cause;
  logic [XLEN-1:0]    eff_tval;
  logic               route_s;
  logic [XLEN-1:0]    cause_word;
  logic [XLEN-1:0]    tvec_arr [NUM_LEVELS];
  logic [XLEN-1:0]    vec_pc   [NUM_LEVELS];

  trap_cause_sel #(.XLEN(XLEN), .CAUSE_W(CAUSE_W)) u_cause (
    .is_irq    (trap_is_irq),
    .cause_in  (trap_cause),
    .priv      (priv_q),
    .fault_addr(trap_addr),
    .cause_out (eff_cause),
    .tval      (eff_tval)
  );

  trap_router #(.CAUSE_W(CAUSE_W)) u_route (
    .is_irq(trap_is_irq),
    .cause (eff_cause),
    .priv  (priv_q),
    .edeleg(edeleg),
    .ideleg(ideleg),
    .to_s  (route_s)
  );

  assign tvec_arr[0] = stvec;
  assign tvec_arr[1] = mtvec;

  for (genvar g = 0; g < NUM_LEVELS; g++) begin : g_vec
    trap_vec_calc #(.XLEN(XLEN), .CAUSE_W(CAUSE_W)) u_vec (
      .tvec  (tvec_arr[g]),
      .is_irq(trap_is_irq),
      .cause (eff_cause),
      .vec_pc(vec_pc[g])
    );
  end

  assign cause_word = {trap_is_irq, {PAD_W{1'b0}}, eff_cause};

  // next-state logic
  always_comb begin
    priv_n   = priv_q;
    sie_n    = sie_q;
    spie_n   = spie_q;
    spp_n    = spp_q;
    mie_n    = mie_q;
    mpie_n   = mpie_q;
    mpp_n    = mpp_q;
    scause_n = scause_q;
    sepc_n   = sepc_q;
    stval_n  = stval_q;
    mcause_n = mcause_q;
    mepc_n   = mepc_q;
    mtval_n  = mtval_q;
    pc_n     = pc_q;
    if (trap_valid) begin
      if (route_s) begin
        spie_n   = sie_q;
        spp_n    = (priv_q == PRIV_S);
        sie_n    = 1'b0;
        scause_n = cause_word;
        sepc_n   = cur_pc;
        stval_n  = eff_tval;
        pc_n     = vec_pc[0];
        priv_n   = PRIV_S;
      end else begin
        mpie_n   = mie_q;
        mpp_n    = priv_q;
        mie_n    = 1'b0;
        mcause_n = cause_word;
        mepc_n   = cur_pc;
        mtval_n  = eff_tval;
        pc_n     = vec_pc[1];
        priv_n   = PRIV_M;
      end
    end else if (st_wr_en) begin
      priv_n = (st_wr_priv == PRIV_RSV) ? PRIV_U : st_wr_priv;
      sie_n  = st_wr_sie;
      mie_n  = st_wr_mie;
    end
  end

  logic upd_en;
  assign upd_en = trap_valid | st_wr_en;

  // register process with explicit enable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      priv_q   <= PRIV_M;
      sie_q    <= 1'b0;
      spie_q   <= 1'b0;
      spp_q    <= 1'b0;
      mie_q    <= 1'b0;
      mpie_q   <= 1'b0;
      mpp_q    <= 2'b00;
      scause_q <= '0;
      sepc_q   <= '0;
      stval_q  <= '0;
      mcause_q <= '0;
      mepc_q   <= '0;
      mtval_q  <= '0;
      pc_q     <= '0;
    end else if (upd_en) begin
      priv_q   <= priv_n;
      sie_q    <= sie_n;
      spie_q   <= spie_n;
      spp_q    <= spp_n;
      mie_q    <= mie_n;
      mpie_q   <= mpie_n;
      mpp_q    <= mpp_n;
      scause_q <= scause_n;
      sepc_q   <= sepc_n;
      stval_q  <= stval_n;
      mcause_q <= mcause_n;
      mepc_q   <= mepc_n;
      mtval_q  <= mtval_n;
      pc_q     <= pc_n;
    end
  end

  assign priv_o   = priv_q;
  assign sie_o    = sie_q;
  assign spie_o   = spie_q;
  assign spp_o    = spp_q;
  assign mie_o    = mie_q;
  assign mpie_o   = mpie_q;
  assign mpp_o    = mpp_q;
  assign scause_o = scause_q;
  assign sepc_o   = sepc_q;
  assign stval_o  = stval_q;
  assign mcause_o = mcause_q;
  assign mepc_o   = mepc_q;
  assign mtval_o  = mtval_q;
  assign pc_o     = pc_q;
endmodule

// File: rtl/trap_entry_ctrl_chk.sv
module trap_entry_ctrl_chk #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            trap_valid,
  input logic            trap_is_irq,
  input logic            st_wr_en,
  input logic [XLEN-1:0] cur_pc,
  input logic [1:0]      priv_o,
  input logic            sie_o,
  input logic            mie_o,
  input logic [XLEN-1:0] sepc_o,
  input logic [XLEN-1:0] mepc_o,
  input logic [XLEN-1:0] scause_o,
  input logic [XLEN-1:0] mcause_o,
  input logic [XLEN-1:0] pc_o
);
  p_machine_never_delegates_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_valid && priv_o == 2'd3) |=> (priv_o == 2'd3));

  p_target_enable_cleared_r6: assert property (@(posedge clk) disable iff (!rst_n)
    trap_valid |=> ((priv_o == 2'd1) ? !sie_o : !mie_o));

  p_epc_captured_r8: assert property (@(posedge clk) disable iff (!rst_n)
    trap_valid |=> ((priv_o == 2'd3) ? (mepc_o == $past(cur_pc)) : (sepc_o == $past(cur_pc))));

  p_cause_msb_r8: assert property (@(posedge clk) disable iff (!rst_n)
    trap_valid |=> ((priv_o == 2'd3) ? (mcause_o[XLEN-1] == $past(trap_is_irq))
                                     : (scause_o[XLEN-1] == $past(trap_is_irq))));

  p_exc_pc_aligned_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_valid && !trap_is_irq) |=> (pc_o[1:0] == 2'b00));

  p_priv_legal_r10: assert property (@(posedge clk) disable iff (!rst_n)
    priv_o != 2'd2);

  p_idle_holds_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (!trap_valid && !st_wr_en) |=> ($stable(priv_o) && $stable(mepc_o) && $stable(sepc_o)
                                    && $stable(pc_o) && $stable(sie_o) && $stable(mie_o)));
endmodule

bind trap_entry_ctrl trap_entry_ctrl_chk #(.XLEN(XLEN)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .trap_valid (trap_valid),
  .trap_is_irq(trap_is_irq),
  .st_wr_en   (st_wr_en),
  .cur_pc     (cur_pc),
  .priv_o     (priv_o),
  .sie_o      (sie_o),
  .mie_o      (mie_o),
  .sepc_o     (sepc_o),
  .mepc_o     (mepc_o),
  .scause_o   (scause_o),
  .mcause_o   (mcause_o),
  .pc_o       (pc_o)
);

// File: tb/trap_entry_ctrl_tb.sv
module trap_entry_ctrl_tb;
  localparam int XLEN = 32;
  localparam int CW   = 5;
  localparam int NC   = 1 << CW;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            trap_valid, trap_is_irq;
  logic [CW-1:0]   trap_cause;
  logic [XLEN-1:0] trap_addr, cur_pc, stvec, mtvec;
  logic [NC-1:0]   edeleg, ideleg;
  logic            st_wr_en, st_wr_sie, st_wr_mie;
  logic [1:0]      st_wr_priv;
  logic [1:0]      priv_o, mpp_o;
  logic            sie_o, spie_o, spp_o, mie_o, mpie_o;
  logic [XLEN-1:0] scause_o, sepc_o, stval_o, mcause_o, mepc_o, mtval_o, pc_o;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  // bench model of the architectural state
  logic [1:0]      e_priv, e_mpp;
  logic            e_sie, e_spie, e_spp, e_mie, e_mpie;
  logic [XLEN-1:0] e_scause, e_sepc, e_stval, e_mcause, e_mepc, e_mtval, e_pc;

  always #10 clk = ~clk;

  trap_entry_ctrl #(.XLEN(XLEN), .CAUSE_W(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .trap_valid(trap_valid), .trap_is_irq(trap_is_irq),
    .trap_cause(trap_cause), .trap_addr(trap_addr), .cur_pc(cur_pc),
    .edeleg(edeleg), .ideleg(ideleg), .stvec(stvec), .mtvec(mtvec),
    .st_wr_en(st_wr_en), .st_wr_priv(st_wr_priv), .st_wr_sie(st_wr_sie),
    .st_wr_mie(st_wr_mie), .priv_o(priv_o), .sie_o(sie_o), .spie_o(spie_o),
    .spp_o(spp_o), .mie_o(mie_o), .mpie_o(mpie_o), .mpp_o(mpp_o),
    .scause_o(scause_o), .sepc_o(sepc_o), .stval_o(stval_o),
    .mcause_o(mcause_o), .mepc_o(mepc_o), .mtval_o(mtval_o), .pc_o(pc_o)
  );

  task automatic check(input string tag, input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // R4: environment-call rewrite by privilege
  function automatic logic [CW-1:0] f_cause(input logic irq, input logic [CW-1:0] c, input logic [1:0] p);
    if (irq || c != 5'd8) return c;
    if (p == 2'd1) return 5'd9;
    if (p == 2'd3) return 5'd11;
    return 5'd8;
  endfunction

  // R5: causes that carry the address
  function automatic logic f_addr_cause(input logic irq, input logic [CW-1:0] c);
    if (irq) return 1'b0;
    return (c inside {5'd0, 5'd1, 5'd4, 5'd5, 5'd6, 5'd7, 5'd12, 5'd13, 5'd15});
  endfunction

  // R2, R3: routing
  function automatic logic f_to_s(input logic irq, input logic [CW-1:0] c, input logic [1:0] p);
    logic [NC-1:0] d;
    d = irq ? ideleg : edeleg;
    return (p != 2'd3) && d[c];
  endfunction

  // R9: new PC
  function automatic logic [XLEN-1:0] f_pc(input logic [XLEN-1:0] tv, input logic irq, input logic [CW-1:0] c);
    logic [XLEN-1:0] r;
    r = tv & ~32'h3;
    if (irq && tv[1:0] == 2'b01) r = r + 32'(c) * 4;
    return r;
  endfunction

  task automatic model_update();
    logic [CW-1:0] c;
    logic [XLEN-1:0] tv;
    if (trap_valid) begin
      c  = f_cause(trap_is_irq, trap_cause, e_priv);
      tv = f_addr_cause(trap_is_irq, c) ? trap_addr : '0;
      if (f_to_s(trap_is_irq, c, e_priv)) begin
        e_spie = e_sie; e_spp = (e_priv == 2'd1); e_sie = 1'b0;
        e_scause = {trap_is_irq, 26'd0, c}; e_sepc = cur_pc; e_stval = tv;
        e_pc = f_pc(stvec, trap_is_irq, c); e_priv = 2'd1;
      end else begin
        e_mpie = e_mie; e_mpp = e_priv; e_mie = 1'b0;
        e_mcause = {trap_is_irq, 26'd0, c}; e_mepc = cur_pc; e_mtval = tv;
        e_pc = f_pc(mtvec, trap_is_irq, c); e_priv = 2'd3;
      end
    end else if (st_wr_en) begin
      e_priv = (st_wr_priv == 2'd2) ? 2'd0 : st_wr_priv;
      e_sie = st_wr_sie; e_mie = st_wr_mie;
    end
  endtask

  task automatic compare_all(input string pfx);
    check({pfx, " R10 priv"},   32'(priv_o), 32'(e_priv));
    check({pfx, " R6 sie"},     32'(sie_o),  32'(e_sie));
    check({pfx, " R6 spie"},    32'(spie_o), 32'(e_spie));
    check({pfx, " R6 spp"},     32'(spp_o),  32'(e_spp));
    check({pfx, " R7 mie"},     32'(mie_o),  32'(e_mie));
    check({pfx, " R7 mpie"},    32'(mpie_o), 32'(e_mpie));
    check({pfx, " R7 mpp"},     32'(mpp_o),  32'(e_mpp));
    check({pfx, " R8 scause"},  scause_o, e_scause);
    check({pfx, " R8 sepc"},    sepc_o,   e_sepc);
    check({pfx, " R5 stval"},   stval_o,  e_stval);
    check({pfx, " R8 mcause"},  mcause_o, e_mcause);
    check({pfx, " R8 mepc"},    mepc_o,   e_mepc);
    check({pfx, " R5 mtval"},   mtval_o,  e_mtval);
    check({pfx, " R9 pc"},      pc_o,     e_pc);
  endtask

  // inputs already set after a falling edge; one rising edge, then sample at falling edge
  task automatic step(input string pfx);
    @(posedge clk);
    model_update();
    @(negedge clk);
    compare_all(pfx);
    trap_valid = 1'b0;
    st_wr_en   = 1'b0;
  endtask

  task automatic do_trap(input logic irq, input logic [CW-1:0] c, input string pfx);
    trap_valid = 1'b1; trap_is_irq = irq; trap_cause = c;
    trap_addr = $urandom; cur_pc = $urandom;
    step(pfx);
  endtask

  task automatic do_write(input logic [1:0] p, input logic s, input logic m, input string pfx);
    st_wr_en = 1'b1; st_wr_priv = p; st_wr_sie = s; st_wr_mie = m;
    step(pfx);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20250611));
    rst_n = 1'b0;
    trap_valid = 0; trap_is_irq = 0; trap_cause = 0; trap_addr = 0; cur_pc = 0;
    edeleg = 0; ideleg = 0; stvec = 32'h0000_2000; mtvec = 32'h0000_1000;
    st_wr_en = 0; st_wr_priv = 0; st_wr_sie = 0; st_wr_mie = 0;
    e_priv = 2'd3; e_mpp = 0; e_sie = 0; e_spie = 0; e_spp = 0; e_mie = 0; e_mpie = 0;
    e_scause = 0; e_sepc = 0; e_stval = 0; e_mcause = 0; e_mepc = 0; e_mtval = 0; e_pc = 0;
    repeat (3) @(negedge clk);
    compare_all("R1 reset held");
    rst_n = 1'b1;
    @(negedge clk);
    compare_all("R1 after release");

    // R4 / R3: ecall from M, delegation bit 11 set but M never delegates
    edeleg = 32'h0000_0800;
    do_trap(1'b0, 5'd8, "ecall-M");
    check("R4 ecall from M cause 11", mcause_o, 32'd11);
    check("R3 M stays M", 32'(priv_o), 32'd3);

    // R4 / R3: from U with bit 8 delegated -> S, cause 8
    edeleg = 32'h0000_0100;
    do_write(2'd0, 1'b1, 1'b1, "wr-U");
    do_trap(1'b0, 5'd8, "ecall-U");
    check("R4 ecall from U cause 8", scause_o, 32'd8);
    check("R3 U delegated to S", 32'(priv_o), 32'd1);
    check("R6 spp from U", 32'(spp_o), 32'd0);

    // R4: from S, bit 9 not delegated -> M, cause 9, MPP 1
    do_trap(1'b0, 5'd8, "ecall-S");
    check("R4 ecall from S cause 9", mcause_o, 32'd9);
    check("R7 mpp from S", 32'(mpp_o), 32'd1);

    // R4: from S with bit 9 delegated -> S, SPP 1
    edeleg = 32'h0000_0200;
    do_write(2'd1, 1'b1, 1'b0, "wr-S");
    do_trap(1'b0, 5'd8, "ecall-S-deleg");
    check("R4 delegation on rewritten cause", 32'(priv_o), 32'd1);
    check("R6 spp from S", 32'(spp_o), 32'd1);

    // R2: interrupt uses ideleg, exception uses edeleg
    edeleg = 32'h0; ideleg = 32'h0000_0020;
    do_write(2'd0, 1'b0, 1'b0, "wr-U2");
    do_trap(1'b1, 5'd5, "irq5");
    check("R2 irq routed by ideleg", 32'(priv_o), 32'd1);
    check("R5 irq tval zero", stval_o, 32'd0);
    do_write(2'd0, 1'b0, 1'b0, "wr-U3");
    do_trap(1'b0, 5'd5, "exc5");
    check("R2 exc routed by edeleg", 32'(priv_o), 32'd3);

    // R9: vectored and direct
    mtvec = 32'h0000_1001;
    do_trap(1'b1, 5'd7, "vec-irq");
    check("R9 vectored irq pc", pc_o, 32'h0000_101C);
    do_trap(1'b0, 5'd7, "vec-exc");
    check("R9 exception base pc", pc_o, 32'h0000_1000);
    mtvec = 32'h0000_1002;
    do_trap(1'b1, 5'd7, "mode2-irq");
    check("R9 mode 2 irq no offset", pc_o, 32'h0000_1000);

    // R11: reserved privilege and trap precedence
    do_write(2'd2, 1'b1, 1'b1, "wr-rsv");
    check("R11 reserved priv stored as 0", 32'(priv_o), 32'd0);
    st_wr_en = 1'b1; st_wr_priv = 2'd1; st_wr_sie = 1'b1; st_wr_mie = 1'b1;
    do_trap(1'b0, 5'd2, "trap+wr");
    check("R11 trap wins over write", 32'(priv_o), 32'd3);
    check("R11 write dropped mie", 32'(mie_o), 32'd0);

    // R12: idle cycles with busy inputs
    for (int i = 0; i < 4; i++) begin
      trap_cause = $urandom; cur_pc = $urandom; trap_addr = $urandom;
      edeleg = $urandom; ideleg = $urandom;
      step("R12 idle hold");
    end

    // random mix
    for (int i = 0; i < 1500; i++) begin
      edeleg = $urandom; ideleg = $urandom;
      stvec = $urandom; mtvec = $urandom;
      if (($urandom % 4) == 0) begin
        st_wr_en = 1'b1; st_wr_priv = 2'($urandom); st_wr_sie = 1'($urandom); st_wr_mie = 1'($urandom);
      end
      trap_valid  = (($urandom % 3) != 0);
      trap_is_irq = 1'($urandom);
      trap_cause  = (($urandom % 4) == 0) ? 5'd8 : 5'($urandom);
      trap_addr   = $urandom; cur_pc = $urandom;
      step("rand");
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule